// File: doc/BRIEF.md
# Keyed-Sequence Watchdog Timer

This block is a watchdog timer that sits on a simple register port. It has four 32-bit words: control/status, counter, timeout and window. Software protects its configuration with key words written to the counter word. One pair of keys in a fixed order opens the configuration for a limited time. Another pair of keys restarts the count. Once enabled, the counter advances on ticks from one of four sources. When the count reaches the programmed timeout, the block sets a sticky flag and issues a reset pulse to the rest of the chip.

A non-zero window makes a refresh that comes too early an error. A malformed key written while the block is running and locked is also an error. Both of these errors also raise the reset. Status bits in the control word show software when the configuration is open and when a configuration write has taken effect. The update-permission bit lets software seal the configuration for good.

Top module: `kwd_top`

## Requirements
- R1: After reset the control word reads 0x0000_0020 (only the update-permission bit, bit 5, set). The timeout word reads the `TOVAL_RST` parameter, the window and counter words read 0, and `wdog_rst_o` is low.
- R2: Two counter-word writes (byte offset 0x4) of 0x0000_C520 and then 0x0000_D928 set control bit 11 (unlocked) and clear bit 10 (applied) in the cycle after the second write. Writes to other words between the two do not break the pair. The pair has effect only while bit 5 is 1.
- R3: While bit 11 is 0, writes to the timeout word (0x8, bits 15:0), the window word (0xC, bits 15:0) and the configuration fields of the control word (0x0) leave their read-back values unchanged.
- R4: A control-word write while unlocked latches bit 7 (enable), bits 9:8 (tick source) and bit 5, sets bit 10 and zeroes the count. If bit 5 is written 0, bit 11 drops at once and every later unlock pair is ignored.
- R5: If no configuration write arrives, bit 11 returns to 0 `UNLOCK_CYC` clocks after the unlock, or after the last configuration write, whichever is later.
- R6: While bit 7 is set, the count (read at 0x4, bits 15:0) rises by one on each tick of the selected source: 0 = every clock, 1 = `tick_lp`, 2 = `tick_hf`, 3 = `tick_ext`. Ticks from the other sources do not advance it.
- R7: On a counted tick where count+1 is at least the timeout value, the count returns to 0 and control bit 14 (flag) is set. `wdog_rst_o` is high for exactly the cycle after that edge.
- R8: Two counter-word writes of 0x0000_A602 and then 0x0000_B480 zero the count. With a window of 0, such a refresh never raises the reset.
- R9: If the window is non-zero and the block is enabled, a refresh that completes while the count is below the window value zeroes the count, sets the flag and pulses `wdog_rst_o`. A refresh at or above the window value does not.
- R10: Any other counter-word write, including a second key without its matching first key, cancels a pending pair. If the block is enabled and locked, such a write pulses `wdog_rst_o` and sets the flag. If the block is disabled or unlocked, it does neither.
- R11: Writing 1 to control bit 14 clears the flag whether or not the block is unlocked. A reset cause in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_word | input | 2 | Word index (byte offset / 4): 0 control, 1 counter, 2 timeout, 3 window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the indexed word, combinational |
| tick_lp | input | 1 | Low-power (1 kHz) tick enable |
| tick_hf | input | 1 | 32 kHz tick enable |
| tick_ext | input | 1 | External tick enable |
| wdog_rst_o | output | 1 | Registered reset request pulse |

## Verification
Every register effect is sampled at a clock edge. A write or tick seen at edge N shows on `bus_rdata` from just after edge N. The reset pulse and the flag of a cause seen at edge N appear together after edge N and last exactly one cycle. The bench's behavioural model advances at the same edge as the design, and the comparison against it happens late in each cycle, after all stimulus for that cycle has settled. The directed checks count whole clock cycles from the end of a write. For example, the timeout test expects the reset to be low four cycles after enabling with a timeout of 5 and high in the fifth.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

    localparam int REG_W = 32;
    localparam int CNT_W = 16;

    // word indices on the register port
    localparam logic [1:0] WS_CTRL = 2'd0;
    localparam logic [1:0] WS_CNT  = 2'd1;
    localparam logic [1:0] WS_TOV  = 2'd2;
    localparam logic [1:0] WS_WIN  = 2'd3;

    // control word bit positions
    localparam int B_UPD     = 5;
    localparam int B_EN      = 7;
    localparam int B_SRC_LO  = 8;
    localparam int B_APPLIED = 10;
    localparam int B_UNLK    = 11;
    localparam int B_FLAG    = 14;

    // key words written to the counter word
    localparam logic [REG_W-1:0] KEY_REF_A = 32'h0000_A602;
    localparam logic [REG_W-1:0] KEY_REF_B = 32'h0000_B480;
    localparam logic [REG_W-1:0] KEY_UNL_A = 32'h0000_C520;
    localparam logic [REG_W-1:0] KEY_UNL_B = 32'h0000_D928;

    localparam int NSRC = 4;

    typedef enum logic [1:0] {
        SRC_BUS = 2'd0,
        SRC_LP  = 2'd1,
        SRC_HF  = 2'd2,
        SRC_EXT = 2'd3
    } tick_src_e;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_REF  = 2'd1,
        SEQ_UNL  = 2'd2
    } seq_e;

    typedef struct packed {
        logic             en;
        logic             upd;
        tick_src_e        src;
        logic [CNT_W-1:0] toval;
        logic [CNT_W-1:0] win;
    } cfg_t;

    typedef struct packed {
        logic refresh;
        logic unlock;
        logic bad;
    } key_ev_t;

    function automatic logic [REG_W-1:0] ctrl_word(input logic flag,
                                                   input logic unl,
                                                   input logic app,
                                                   input cfg_t c);
        logic [REG_W-1:0] w;
        w                  = '0;
        w[B_FLAG]          = flag;
        w[B_UNLK]          = unl;
        w[B_APPLIED]       = app;
        w[B_SRC_LO +: 2]   = c.src;
        w[B_EN]            = c.en;
        w[B_UPD]           = c.upd;
        return w;
    endfunction

endpackage

// File: rtl/kwd_keyseq.sv
module kwd_keyseq
    import kwd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_wr,
    input  logic [REG_W-1:0] wdata,
    output key_ev_t          ev
);

    seq_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        ev   = '0;
        if (cnt_wr) begin
            st_d = SEQ_IDLE;
            if (wdata == KEY_REF_A) begin
                st_d = SEQ_REF;
            end else if (wdata == KEY_UNL_A) begin
                st_d = SEQ_UNL;
            end else if (st_q == SEQ_REF && wdata == KEY_REF_B) begin
                ev.refresh = 1'b1;
            end else if (st_q == SEQ_UNL && wdata == KEY_UNL_B) begin
                ev.unlock = 1'b1;
            end else begin
                ev.bad = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= SEQ_IDLE;
        else     st_q <= st_d;
    end

endmodule

// File: rtl/kwd_cfg.sv
module kwd_cfg
    import kwd_pkg::*;
#(
    parameter int               UNLOCK_CYC = 256,
    parameter logic [CNT_W-1:0] TOVAL_RST  = 16'h1000
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [1:0]       word_sel,
    input  logic [REG_W-1:0] wdata,
    input  logic             unlock_ev,
    input  logic             set_flag,
    output cfg_t             cfg,
    output logic             unlocked,
    output logic             applied,
    output logic             flag,
    output logic             ctrl_apply
);

    localparam int               TMR_W    = $clog2(UNLOCK_CYC + 1);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(UNLOCK_CYC - 1);

    logic [TMR_W-1:0] tmr_q;
    logic             wr_ctrl, wr_tov, wr_win, cfg_wr;

    assign wr_ctrl    = bus_wr && (word_sel == WS_CTRL);
    assign wr_tov     = bus_wr && (word_sel == WS_TOV);
    assign wr_win     = bus_wr && (word_sel == WS_WIN);
    assign cfg_wr     = unlocked && (wr_ctrl || wr_tov || wr_win);
    assign ctrl_apply = unlocked && wr_ctrl;

    // unlock window and its timer
    always_ff @(posedge clk) begin
        if (rst) begin
            unlocked <= 1'b0;
            tmr_q    <= '0;
        end else if (unlock_ev && cfg.upd) begin
            unlocked <= 1'b1;
            tmr_q    <= '0;
        end else if (unlocked) begin
            if (cfg_wr) begin
                tmr_q <= '0;
                if (ctrl_apply && !wdata[B_UPD]) unlocked <= 1'b0;
            end else if (tmr_q == TMR_LAST) begin
                unlocked <= 1'b0;
            end else begin
                tmr_q <= tmr_q + 1'b1;
            end
        end
    end

    // configuration fields
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg     <= '{en: 1'b0, upd: 1'b1, src: SRC_BUS, toval: TOVAL_RST, win: '0};
            applied <= 1'b0;
        end else begin
            if (unlock_ev && cfg.upd) applied <= 1'b0;
            if (ctrl_apply) begin
                cfg.en  <= wdata[B_EN];
                cfg.upd <= wdata[B_UPD];
                cfg.src <= tick_src_e'(wdata[B_SRC_LO +: 2]);
                applied <= 1'b1;
            end
            if (unlocked && wr_tov) cfg.toval <= wdata[CNT_W-1:0];
            if (unlocked && wr_win) cfg.win   <= wdata[CNT_W-1:0];
        end
    end

    // sticky flag, set wins over write-one-to-clear
    always_ff @(posedge clk) begin
        if (rst)                          flag <= 1'b0;
        else if (set_flag)                flag <= 1'b1;
        else if (wr_ctrl && wdata[B_FLAG]) flag <= 1'b0;
    end

endmodule

// File: rtl/kwd_counter.sv
module kwd_counter
    import kwd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  tick_src_e        src,
    input  logic [CNT_W-1:0] toval,
    input  logic [NSRC-1:0]  tick_vec,
    input  logic             clear,
    output logic [CNT_W-1:0] cnt,
    output logic             fire
);

    logic [NSRC-1:0] hit;
    logic            tick;
    logic [CNT_W:0]  nxt;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign hit[g] = tick_vec[g] && (int'(src) == g);
    end

    assign tick = |hit;
    assign nxt  = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
    assign fire = en && tick && !clear && (nxt >= {1'b0, toval});

    always_ff @(posedge clk) begin
        if (rst)                cnt <= '0;
        else if (clear || fire) cnt <= '0;
        else if (en && tick)    cnt <= nxt[CNT_W-1:0];
    end

endmodule

// File: rtl/kwd_top.sv
module kwd_top
    import kwd_pkg::*;
#(
    parameter int               UNLOCK_CYC = 256,
    parameter logic [CNT_W-1:0] TOVAL_RST  = 16'h1000
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [1:0]       bus_word,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             tick_lp,
    input  logic             tick_hf,
    input  logic             tick_ext,
    output logic             wdog_rst_o
);

    key_ev_t          ev;
    cfg_t             cfg_q;
    logic             unlocked, applied, flag_q, ctrl_apply;
    logic [CNT_W-1:0] cnt_q;
    logic             fire, early, bad_rst, cause;
    logic [NSRC-1:0]  tick_vec;

    assign tick_vec = {tick_ext, tick_hf, tick_lp, 1'b1};

    kwd_keyseq u_keys (
        .clk    (clk),
        .rst    (rst),
        .cnt_wr (bus_wr && (bus_word == WS_CNT)),
        .wdata  (bus_wdata),
        .ev     (ev)
    );

    kwd_cfg #(
        .UNLOCK_CYC (UNLOCK_CYC),
        .TOVAL_RST  (TOVAL_RST)
    ) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .bus_wr     (bus_wr),
        .word_sel   (bus_word),
        .wdata      (bus_wdata),
        .unlock_ev  (ev.unlock),
        .set_flag   (cause),
        .cfg        (cfg_q),
        .unlocked   (unlocked),
        .applied    (applied),
        .flag       (flag_q),
        .ctrl_apply (ctrl_apply)
    );

    kwd_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .en       (cfg_q.en),
        .src      (cfg_q.src),
        .toval    (cfg_q.toval),
        .tick_vec (tick_vec),
        .clear    (ctrl_apply || ev.refresh),
        .cnt      (cnt_q),
        .fire     (fire)
    );

    assign early   = ev.refresh && cfg_q.en && (cfg_q.win != '0) && (cnt_q < cfg_q.win);
    assign bad_rst = ev.bad && cfg_q.en && !unlocked;
    assign cause   = fire || early || bad_rst;

    always_ff @(posedge clk) begin
        if (rst) wdog_rst_o <= 1'b0;
        else     wdog_rst_o <= cause;
    end

    always_comb begin
        unique case (bus_word)
            WS_CTRL: bus_rdata = ctrl_word(flag_q, unlocked, applied, cfg_q);
            WS_CNT:  bus_rdata = {{(REG_W-CNT_W){1'b0}}, cnt_q};
            WS_TOV:  bus_rdata = {{(REG_W-CNT_W){1'b0}}, cfg_q.toval};
            default: bus_rdata = {{(REG_W-CNT_W){1'b0}}, cfg_q.win};
        endcase
    end

endmodule

// File: rtl/kwd_checker.sv
module kwd_checker
    import kwd_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             bus_wr,
    input logic [1:0]       bus_word,
    input logic [REG_W-1:0] bus_wdata,
    input logic             wdog_rst_o,
    input logic             flag,
    input logic             unlocked,
    input logic             applied,
    input cfg_t             cfg,
    input logic [CNT_W-1:0] cnt
);

    assert_flag_with_rst_R7: assert property (@(posedge clk) disable iff (rst)
        wdog_rst_o |-> flag);

    assert_unlock_key_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(unlocked) |-> $past(bus_wr && bus_word == WS_CNT && bus_wdata == KEY_UNL_B));

    assert_applied_by_ctrl_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(applied) |-> $past(bus_wr && bus_word == WS_CTRL && unlocked));

    assert_toval_locked_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg.toval) |-> $past(unlocked));

    assert_win_locked_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg.win) |-> $past(unlocked));

    assert_cnt_step_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(cnt) |-> (cnt == '0 || cnt == $past(cnt) + 16'd1));

endmodule

bind kwd_top kwd_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_word   (bus_word),
    .bus_wdata  (bus_wdata),
    .wdog_rst_o (wdog_rst_o),
    .flag       (flag_q),
    .unlocked   (unlocked),
    .applied    (applied),
    .cfg        (cfg_q),
    .cnt        (cnt_q)
);

// File: tb/kwd_top_bench.sv
module kwd_top_bench;

    localparam int LIM  = 16;
    localparam int TRST = 16'h1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_word = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_lp = 1'b0, tick_hf = 1'b0, tick_ext = 1'b0;
    logic        wdog_rst_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    kwd_top #(.UNLOCK_CYC(LIM), .TOVAL_RST(16'h1000)) u_kwd_top (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_word(bus_word),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_lp(tick_lp),
        .tick_hf(tick_hf), .tick_ext(tick_ext), .wdog_rst_o(wdog_rst_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int m_seq, m_seq_n, m_tmr, m_src, m_tov, m_win, m_cnt, ws;
    bit m_unl, m_app, m_en, m_upd, m_flag, m_rst;
    bit ref_e, unl_e, bad_e, capply, cfgw, tk, fire, early, badr;

    always @(posedge clk) begin
        if (rst) begin
            m_seq = 0; m_tmr = 0; m_src = 0; m_tov = TRST; m_win = 0; m_cnt = 0;
            m_unl = 0; m_app = 0; m_en = 0; m_upd = 1; m_flag = 0; m_rst = 0;
        end else begin
            ws = int'(bus_word);
            ref_e = 0; unl_e = 0; bad_e = 0;
            m_seq_n = m_seq;
            if (bus_wr && ws == 1) begin
                if (bus_wdata == 32'hA602) m_seq_n = 1;
                else if (bus_wdata == 32'hC520) m_seq_n = 2;
                else begin
                    m_seq_n = 0;
                    if (m_seq == 1 && bus_wdata == 32'hB480) ref_e = 1;
                    else if (m_seq == 2 && bus_wdata == 32'hD928) unl_e = 1;
                    else bad_e = 1;
                end
            end
            capply = bus_wr && ws == 0 && m_unl;
            cfgw   = bus_wr && ws != 1 && m_unl;
            tk = (m_src == 0) || (m_src == 1 && tick_lp) || (m_src == 2 && tick_hf) || (m_src == 3 && tick_ext);
            fire  = m_en && tk && !capply && !ref_e && (m_cnt + 1 >= m_tov);
            early = ref_e && m_en && m_win != 0 && m_cnt < m_win;
            badr  = bad_e && m_en && !m_unl;
            if (capply || ref_e || fire) m_cnt = 0;
            else if (m_en && tk) m_cnt = m_cnt + 1;
            if (fire || early || badr) m_flag = 1;
            else if (bus_wr && ws == 0 && bus_wdata[14]) m_flag = 0;
            m_rst = fire || early || badr;
            if (unl_e && m_upd) begin
                m_unl = 1; m_tmr = 0; m_app = 0;
            end else if (m_unl) begin
                if (cfgw) begin
                    m_tmr = 0;
                    if (capply && !bus_wdata[5]) m_unl = 0;
                end else if (m_tmr == LIM - 1) m_unl = 0;
                else m_tmr = m_tmr + 1;
            end
            if (capply) begin
                m_en = bus_wdata[7]; m_upd = bus_wdata[5]; m_src = int'(bus_wdata[9:8]); m_app = 1;
            end
            if (cfgw && ws == 2) m_tov = int'(bus_wdata[15:0]);
            if (cfgw && ws == 3) m_win = int'(bus_wdata[15:0]);
            m_seq = m_seq_n;
        end
    end

    function automatic logic [31:0] model_rd(input int w);
        logic [31:0] r;
        r = '0;
        case (w)
            0: begin r[14] = m_flag; r[11] = m_unl; r[10] = m_app; r[9:8] = 2'(m_src); r[7] = m_en; r[5] = m_upd; end
            1: r = 32'(m_cnt);
            2: r = 32'(m_tov);
            default: r = 32'(m_win);
        endcase
        return r;
    endfunction

    // per-cycle comparison late in each cycle
    always @(negedge clk) begin
        #8;
        if (!rst && !done) begin
            chk(wdog_rst_o == m_rst, "R7 R9 R10 model reset output", 32'(wdog_rst_o), 32'(m_rst));
            chk(bus_rdata == model_rd(int'(bus_word)), "R1 R6 model register read", bus_rdata, model_rd(int'(bus_word)));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [1:0] w, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_word = w; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] w, input logic [31:0] mask, input logic [31:0] exp, input string tag);
        bus_word = w;
        #1;
        chk((bus_rdata & mask) == exp, tag, bus_rdata & mask, exp);
    endtask

    task automatic rst_is(input logic exp, input string tag);
        chk(wdog_rst_o == exp, tag, 32'(wdog_rst_o), 32'(exp));
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 1) tick_lp = 1'b1; else tick_ext = 1'b1;
        @(negedge clk);
        tick_lp = 1'b0; tick_ext = 1'b0;
    endtask

    task automatic unlock();
        wr(2'd1, 32'h0000_C520);
        wr(2'd1, 32'h0000_D928);
    endtask

    task automatic refresh();
        wr(2'd1, 32'h0000_A602);
        wr(2'd1, 32'h0000_B480);
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        rd(2'd0, 32'hFFFF_FFFF, 32'h0000_0020, "R1 control reset value");
        rd(2'd2, 32'hFFFF_FFFF, 32'(TRST), "R1 timeout reset value");
        rd(2'd3, 32'hFFFF_FFFF, 32'h0, "R1 window reset value");
        rd(2'd1, 32'hFFFF_FFFF, 32'h0, "R1 counter reset value");
        rst_is(1'b0, "R1 reset output low");

        wr(2'd2, 32'h0000_0077);
        rd(2'd2, 32'hFFFF_FFFF, 32'(TRST), "R3 locked timeout write ignored");

        unlock();
        rd(2'd0, 32'h0000_0C00, 32'h0000_0800, "R2 unlocked set, applied clear");
        wr(2'd1, 32'h0000_0055);
        rst_is(1'b0, "R10 bad key while disabled and unlocked");
        rd(2'd0, 32'h0000_0800, 32'h0000_0800, "R2 still unlocked after bad key");
        wr(2'd2, 32'h0000_0005);
        wr(2'd3, 32'h0000_0000);
        wr(2'd0, 32'h0000_00A0);
        rd(2'd0, 32'h0000_0C80, 32'h0000_0C80, "R4 applied and enabled");
        rd(2'd2, 32'hFFFF_FFFF, 32'h5, "R3 unlocked timeout write taken");
        idle(4);
        rst_is(1'b0, "R7 no reset before timeout");
        rd(2'd1, 32'hFFFF_FFFF, 32'h4, "R6 count after four clocks");
        idle(1);
        rst_is(1'b1, "R7 reset at timeout");
        rd(2'd0, 32'h0000_4000, 32'h0000_4000, "R7 flag set");
        rd(2'd1, 32'hFFFF_FFFF, 32'h0, "R7 count restarted");

        wr(2'd0, 32'h0000_0020);
        rd(2'd0, 32'h0000_4000, 32'h0000_4000, "R11 flag sticky");
        wr(2'd0, 32'h0000_4020);
        rd(2'd0, 32'h0000_4000, 32'h0, "R11 flag cleared by write of one");

        wr(2'd2, 32'h0000_0064);
        wr(2'd0, 32'h0000_01A0);
        pulse(3); pulse(3);
        pulse(1); pulse(1); pulse(1);
        rd(2'd1, 32'hFFFF_FFFF, 32'h3, "R6 only selected ticks counted");

        refresh();
        rd(2'd1, 32'hFFFF_FFFF, 32'h0, "R8 refresh zeroes count");
        rst_is(1'b0, "R8 open window refresh no reset");

        unlock();
        wr(2'd3, 32'h0000_000A);
        wr(2'd0, 32'h0000_00A0);
        refresh();
        rst_is(1'b1, "R9 early refresh resets");
        idle(15);
        refresh();
        rst_is(1'b0, "R9 late refresh accepted");

        idle(20);
        rd(2'd0, 32'h0000_0800, 32'h0, "R5 unlock expired");
        wr(2'd1, 32'h0000_A602);
        wr(2'd3, 32'h0000_0000);
        wr(2'd1, 32'h0000_B480);
        rst_is(1'b0, "R10 pair survives other-word write");
        rd(2'd1, 32'hFFFF_FFFF, 32'h0, "R10 interleaved refresh zeroes count");
        rd(2'd3, 32'hFFFF_FFFF, 32'hA, "R3 locked window write ignored");
        wr(2'd1, 32'h0000_1234);
        rst_is(1'b1, "R10 bad key while enabled and locked");

        unlock();
        wr(2'd0, 32'h0000_0000);
        rd(2'd0, 32'h0000_0C20, 32'h0000_0400, "R4 sealed: unlock closed, applied");
        unlock();
        rd(2'd0, 32'h0000_0800, 32'h0, "R4 unlock ignored after seal");
        wr(2'd2, 32'h0000_0007);
        rd(2'd2, 32'hFFFF_FFFF, 32'h64, "R3 sealed timeout write ignored");

        idle(3);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog expired R1 actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule